// File: doc/BRIEF.md
# Burst Address Counter Register

This block is the address stage of one port of a synchronous memory. On every rising clock edge it picks the address for that cycle's access. It can clear the address to zero, take a new address from the external bus, step the stored address up by one, or keep the stored address unchanged. The address it picks is both used for the access in that same cycle and written into the counter register. Because of this, a clear or a step costs no extra cycle.

All three controls are active low. A burst usually starts with one load of a start address, followed by count-enabled cycles. Holding the load low on every cycle turns the block into a plain registered address input, which can take random addresses. Chip enables do not gate the counter: clear and load act on every edge, and so does the step when it is selected.

Top module: `burst_addr_ctr`

## Requirements
- R1: While the synchronous block reset `rst_n` is low at a clock edge, the stored counter `held_addr` becomes 0.
- R2: When `clear_n` is low, `access_addr` is 0 in that cycle and `held_addr` is 0 after the edge, whatever `load_n` and `count_n` are.
- R3: When `clear_n` is high and `load_n` is low, `access_addr` equals `ext_addr` in that cycle and `held_addr` takes that value at the edge.
- R4: When `clear_n` and `load_n` are high and `count_n` is low, `access_addr` equals `held_addr` + 1 in that same cycle and is stored at the edge.
- R5: When `clear_n`, `load_n` and `count_n` are all high, `access_addr` equals `held_addr` and `ext_addr` has no effect on either output.
- R6: A step from the all-ones address (2^ADDR_W - 1) gives 0.
- R7: After every edge with `rst_n` high, `held_addr` equals the `access_addr` of the cycle before.
- R8: When `load_n` and `count_n` are both low, the load wins and no step is added.
- R9: With `load_n` held low on consecutive cycles, each cycle uses its own `ext_addr`, even when the addresses are not in sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous block reset, active low |
| ext_addr | input | ADDR_W | External address bus |
| load_n | input | 1 | Load strobe, active low |
| count_n | input | 1 | Step enable, active low |
| clear_n | input | 1 | Counter clear, active low, highest priority |
| access_addr | output | ADDR_W | Address used for this cycle's access |
| held_addr | output | ADDR_W | Stored counter value |

## Verification
The bench builds the block with the default `ADDR_W` of 15, which is the full 32K address space. Random mixes of clear, load and step reach only a small part of that space. The wrap from all-ones to zero is therefore reached on purpose, by loading 32767 and then stepping. Random cycles still cover every priority combination of the three controls, and each access and stored value is compared with a bench model.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic [1:0] {
    OP_KEEP  = 2'd0,
    OP_STEP  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } addr_op_e;

  // Step with natural wrap at the register width.
  function automatic logic [31:0] step_addr(input logic [31:0] cur, input int unsigned width);
    logic [31:0] mask;
    mask = (width >= 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 32'd1);
    return (cur + 32'd1) & mask;
  endfunction
endpackage

// File: rtl/burst_ctl_decode.sv
module burst_ctl_decode
  import burst_addr_pkg::*;
(
  input  logic     load_n,
  input  logic     count_n,
  input  logic     clear_n,
  output addr_op_e op
);
  // Priority: clear, then load, then step, else keep.
  always_comb begin
    if (!clear_n)      op = OP_CLEAR;
    else if (!load_n)  op = OP_LOAD;
    else if (!count_n) op = OP_STEP;
    else               op = OP_KEEP;
  end
endmodule

// File: rtl/burst_addr_sel.sv
module burst_addr_sel
  import burst_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  addr_op_e          op,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] sel_addr
);
  logic [31:0] cur_wide;
  logic [31:0] step_wide;

  assign cur_wide  = 32'(cur_addr);
  assign step_wide = step_addr(cur_wide, ADDR_W);

  always_comb begin
    unique case (op)
      OP_CLEAR: sel_addr = '0;
      OP_LOAD:  sel_addr = ext_addr;
      OP_STEP:  sel_addr = step_wide[ADDR_W-1:0];
      default:  sel_addr = cur_addr;
    endcase
  end
endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg #(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  assert_reset_zero_R1: assert property (@(posedge clk) !rst_n |=> q == '0)
    else $error("R1: counter not zero after reset");
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import burst_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              load_n,
  input  logic              count_n,
  input  logic              clear_n,
  output logic [ADDR_W-1:0] access_addr,
  output logic [ADDR_W-1:0] held_addr
);
  localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};

  addr_op_e          op_w;
  logic [ADDR_W-1:0] sel_w;
  logic [ADDR_W-1:0] held_w;

  burst_ctl_decode u_dec (
    .load_n (load_n),
    .count_n(count_n),
    .clear_n(clear_n),
    .op     (op_w)
  );

  burst_addr_sel #(.ADDR_W(ADDR_W)) u_sel (
    .op      (op_w),
    .ext_addr(ext_addr),
    .cur_addr(held_w),
    .sel_addr(sel_w)
  );

  burst_addr_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (sel_w),
    .q    (held_w)
  );

  assign access_addr = sel_w;
  assign held_addr   = held_w;

  assert_clear_now_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |-> access_addr == '0) else $error("R2: clear access");
  assert_clear_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !clear_n) |=> held_addr == '0) else $error("R2: clear store");
  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && !load_n) |-> access_addr == ext_addr) else $error("R3: load");
  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && load_n && !count_n) |-> access_addr == ADDR_W'(held_addr + 1'b1))
    else $error("R4: step");
  assert_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && load_n && count_n) |-> access_addr == held_addr) else $error("R5: keep");
  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && load_n && !count_n && held_addr == ALL_ONES) |-> access_addr == '0)
    else $error("R6: wrap");
  assert_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> held_addr == $past(access_addr)) else $error("R7: track");
endmodule

// File: tb/test_burst_addr_ctr.sv
module test_burst_addr_ctr;
  localparam int unsigned W = 15;
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] ext_addr = '0;
  logic         load_n = 1'b1, count_n = 1'b1, clear_n = 1'b1;
  logic [W-1:0] access_addr, held_addr;

  int checks = 0, fails = 0;
  logic [W-1:0] model = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_addr_ctr #(.ADDR_W(W)) i_burst_addr_ctr (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .load_n(load_n),
    .count_n(count_n), .clear_n(clear_n),
    .access_addr(access_addr), .held_addr(held_addr)
  );

  function automatic logic [W-1:0] expect_addr(logic [W-1:0] cur, logic ld, logic cn,
                                               logic cl, logic [W-1:0] ext);
    if (!cl) return '0;
    if (!ld) return ext;
    if (!cn) return W'({1'b0, cur} + 1);
    return cur;
  endfunction

  function automatic string tag_of(logic [W-1:0] cur, logic ld, logic cn, logic cl);
    if (!cl) return "R2";
    if (!ld) return (!cn) ? "R8" : "R3";
    if (!cn) return (cur == TOP) ? "R6" : "R4";
    return "R5";
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check access before edge, stored value after.
  task automatic step(logic ld, logic cn, logic cl, logic [W-1:0] ext, string force_tag = "");
    logic [W-1:0] e;
    string t;
    @(negedge clk);
    load_n = ld; count_n = cn; clear_n = cl; ext_addr = ext;
    #1;
    e = expect_addr(model, ld, cn, cl, ext);
    t = (force_tag != "") ? force_tag : tag_of(model, ld, cn, cl);
    check(t, access_addr, e);
    @(posedge clk); #1;
    model = e;
    check("R7", held_addr, model);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1", held_addr, '0);
    @(negedge clk); rst_n = 1'b1;

    step(1'b0, 1'b1, 1'b1, 15'd100);            // R3 load
    step(1'b1, 1'b0, 1'b1, 15'd7);              // R4 step
    step(1'b1, 1'b1, 1'b1, 15'd9999);           // R5 bus ignored
    step(1'b1, 1'b1, 1'b1, 15'd1);
    step(1'b0, 1'b0, 1'b1, 15'd500);            // R8 load beats step
    step(1'b0, 1'b0, 1'b0, 15'd42);             // R2 clear beats all
    step(1'b0, 1'b1, 1'b1, TOP);                // load all ones
    step(1'b1, 1'b0, 1'b1, 15'd3);              // R6 wrap to 0
    step(1'b0, 1'b1, 1'b1, 15'd20000, "R9");    // R9 non-sequential loads
    step(1'b0, 1'b1, 1'b1, 15'd5, "R9");
    step(1'b0, 1'b1, 1'b1, 15'd31000, "R9");

    // R1 mid-run block reset
    @(negedge clk); rst_n = 1'b0; load_n = 1'b1; count_n = 1'b1; clear_n = 1'b1;
    @(posedge clk); #1;
    check("R1", held_addr, '0);
    model = '0;
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 600; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      step(r[0], r[1], (r[3:2] != 2'b00), W'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule